// File: doc/BRIEF.md
# Configurable SPI Master/Slave Byte Shifter

This block is a serial peripheral port that moves one byte per transfer in full duplex. As a master it makes the serial clock from the system clock through a selectable divider. It shifts its byte out on MOSI and samples MISO on the edges that the clock-polarity and clock-phase settings choose. As a slave it brings the incoming serial clock, slave select and MOSI into the system clock domain. It detects edges on the synchronized clock and drives its own byte onto MISO. Data always travels most-significant bit first.

Software sets the port up through a configuration write strobe. It then loads a byte through the data write strobe and collects the received byte from the data read port. In master mode the data write starts a transfer. A completion flag is raised at the end of each byte. It is cleared by a status read that sees the flag set, followed by a data read. A data write during a running transfer is discarded and raises a collision flag. When the slave-select pin is enabled as an input and is pulled low while the port is a master, the port falls back to slave and sets the completion flag. Software must then select master mode again.

Top module: `spi_xcvr`

## Requirements
- R1: In master mode with no transfer running, `sck_out` equals the polarity setting (`cfg_cpol`), and it returns to that level after the last edge of a transfer.
- R2: With phase 0 the first data bit is valid on `mosi_out` before the first clock edge, and each bit is sampled on a leading edge (rising for polarity 0, falling for polarity 1).
- R3: With phase 1 each bit is set up on a leading edge and sampled on the trailing edge.
- R4: A master transfer makes exactly 16 clock edges (8 pulses), sends the written byte MSB first and latches the received byte into `dat_rdata` at the eighth sample.
- R5: With `cfg_dbl` = 0, `cfg_rate` values 00, 01, 10 and 11 give a clock period of 4, 16, 64 and 128 system clocks.
- R6: With `cfg_dbl` = 1, `cfg_rate` values 00, 01, 10 and 11 give a clock period of 2, 8, 32 and 64 system clocks.
- R7: When `cfg_ss_en` = 1 and a synchronized low on `ss_n` is seen in master mode, the port clears `master_o`, stops the clock at its idle level, releases `sck_drive` and sets `done_o`. The port stays a slave until a new configuration write selects master. With `cfg_ss_en` = 0, `ss_n` has no effect in master mode.
- R8: In slave mode, `sck_in`, `ss_n` and `mosi_in` are synchronized. The port receives a byte MSB first into `dat_rdata` and sends its loaded byte MSB first on `miso_out`. It sets `done_o` after the sixteenth edge. `cfg_rate` and `cfg_dbl` have no effect on any of this.
- R9: A data write while a transfer is running sets `wcol_o` and leaves both the byte being shifted and the received byte unchanged.
- R10: `done_o` and `wcol_o` are cleared by a data read that follows a status read which saw `done_o` high. A data read without that status read clears nothing. A new completion in the same cycle as the clearing read keeps `done_o` set.
- R11: After reset, `done_o`, `wcol_o`, `master_o`, `sck_out` and `dat_rdata` are all 0.
- R12: With phase 0, a slave presents the MSB of its loaded byte on `miso_out` as soon as it is selected, before any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_master | input | 1 | 1 selects master mode |
| cfg_dbl | input | 1 | Halves the selected divisor |
| cfg_rate | input | 2 | Divider select |
| cfg_ss_en | input | 1 | 1 lets `ss_n` raise a mode fault in master mode |
| dat_wr | input | 1 | Data write strobe |
| dat_wdata | input | DW (8) | Byte to transmit |
| dat_rd | input | 1 | Data read strobe |
| dat_rdata | output | DW (8) | Last received byte |
| stat_rd | input | 1 | Status read strobe |
| done_o | output | 1 | Transfer complete or mode fault |
| wcol_o | output | 1 | Write collision |
| master_o | output | 1 | Current master-select state |
| sck_in | input | 1 | Serial clock from the remote master |
| sck_out | output | 1 | Generated serial clock |
| sck_drive | output | 1 | High while this port drives the clock (master) |
| ss_n | input | 1 | Slave select, active low |
| mosi_in | input | 1 | Serial data in (slave) |
| mosi_out | output | 1 | Serial data out (master) |
| miso_in | input | 1 | Serial data in (master) |
| miso_out | output | 1 | Serial data out (slave) |

## Verification
The completion of a transfer and the software read that clears the completion flag can land on the same system-clock edge. The bench provokes this by counting system clocks from the write that starts a master transfer at the fastest normal divisor. It then places the data-read strobe, armed by an earlier status read, exactly on the sixteenth clock edge. It judges the outcome at the ports: `done_o` must stay high. A second plain data read must not clear it either, because the earlier status read was used up. Only a fresh status-then-data read clears the flag.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

  // Width of the half-period counter; holds the largest half period (64).
  localparam int unsigned HALF_W = 7;

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic       master;
    logic       dbl;
    logic [1:0] rate;
    logic       ss_en;
  } spi_cfg_t;

  // Half of the serial clock period in system clocks.
  // Normal speed: 2, 8, 32, 64; double speed: 1, 4, 16, 32.
  function automatic logic [HALF_W-1:0] half_period(input logic dbl,
                                                    input logic [1:0] rate);
    logic [2:0] ex;
    case (rate)
      2'd0:    ex = 3'd1;
      2'd1:    ex = 3'd3;
      2'd2:    ex = 3'd5;
      default: ex = 3'd6;
    endcase
    if (dbl) ex = ex - 3'd1;
    return HALF_W'(1) << ex;
  endfunction

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_xcvr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       dbl,
  input  logic [1:0] rate,
  output logic       tick
);

  logic [HALF_W-1:0] half;
  logic [HALF_W-1:0] cnt_q, cnt_d;

  always_comb begin
    half = half_period(dbl, rate);
    tick = run && (cnt_q == half - HALF_W'(1));
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + HALF_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          edge_stb,
  input  logic          cpha,
  input  logic          in_bit,
  output logic          out_bit,
  output logic          rx_stb,
  output logic [DW-1:0] rx_byte,
  output logic          last_edge,
  output logic          active
);

  localparam int          EW     = $clog2(2*DW);
  localparam logic [EW-1:0] E_LAST = EW'(2*DW-1);

  logic [EW-1:0] e_q, e_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          rb_q, rb_d;
  logic          sample, shift;

  always_comb begin
    sample    = edge_stb && (e_q[0] == cpha);
    shift     = edge_stb && (e_q[0] != cpha) && !(cpha && (e_q == '0));
    last_edge = edge_stb && (e_q == E_LAST);
    rx_stb    = sample && (e_q[EW-1:1] == (EW-1)'(DW-1));
    rx_byte   = {sh_q[DW-2:0], in_bit};
    active    = (e_q != '0);
    out_bit   = sh_q[DW-1];

    if (restart || last_edge) e_d = '0;
    else if (edge_stb)        e_d = e_q + EW'(1);
    else                      e_d = e_q;

    rb_d = sample ? in_bit : rb_q;

    if (load)       sh_d = load_data;
    else if (shift) sh_d = {sh_q[DW-2:0], rb_q};
    else            sh_d = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_q  <= '0;
      sh_q <= '0;
      rb_q <= 1'b0;
    end else begin
      e_q  <= e_d;
      sh_q <= sh_d;
      rb_q <= rb_d;
    end
  end

endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_xcvr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_cpol,
  input  logic          cfg_cpha,
  input  logic          cfg_master,
  input  logic          cfg_dbl,
  input  logic [1:0]    cfg_rate,
  input  logic          cfg_ss_en,
  input  logic          dat_wr,
  input  logic [DW-1:0] dat_wdata,
  input  logic          dat_rd,
  output logic [DW-1:0] dat_rdata,
  input  logic          stat_rd,
  output logic          done_o,
  output logic          wcol_o,
  output logic          master_o,
  input  logic          sck_in,
  output logic          sck_out,
  output logic          sck_drive,
  input  logic          ss_n,
  input  logic          mosi_in,
  output logic          mosi_out,
  input  logic          miso_in,
  output logic          miso_out
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // Configuration register.
  spi_cfg_t cfg_q, cfg_d;
  logic     modf;

  // Input synchronizers: {sck, ss_n, mosi}
  logic [2:0] pin_sync;
  logic       s_sck, s_ss_n, s_mosi, s_sck_d;

  spi_in_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d     ({sck_in, ss_n, mosi_in}),
    .q     (pin_sync)
  );
  assign {s_sck, s_ss_n, s_mosi} = pin_sync;

  // Master state.
  logic m_busy, m_busy_d;
  logic m_tick, m_start, m_edge;
  logic sck_ph, sck_ph_d;

  // Slave edge detection.
  logic sel, s_edge;

  // Shift engine hookup.
  logic          core_restart, core_load, core_edge, core_in;
  logic          core_out, core_rx_stb, core_last, core_active;
  logic [DW-1:0] core_rx;
  logic          busy_any;

  // Flags and read buffer.
  logic          done_q, done_d, wcol_q, wcol_d, seen_q, seen_d;
  logic          done_set, wcol_set, flag_clr;
  logic [DW-1:0] rx_buf_q, rx_buf_d;

  spi_rate_gen u_rate (
    .clk   (clk),
    .rst_n (rst_q_n),
    .run   (m_busy),
    .dbl   (cfg_q.dbl),
    .rate  (cfg_q.rate),
    .tick  (m_tick)
  );

  spi_shift_core #(.DW(DW)) u_core (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .restart   (core_restart),
    .load      (core_load),
    .load_data (dat_wdata),
    .edge_stb  (core_edge),
    .cpha      (cfg_q.cpha),
    .in_bit    (core_in),
    .out_bit   (core_out),
    .rx_stb    (core_rx_stb),
    .rx_byte   (core_rx),
    .last_edge (core_last),
    .active    (core_active)
  );

  always_comb begin
    // mode fault and slave selection
    modf   = cfg_q.master && cfg_q.ss_en && !s_ss_n;
    sel    = !cfg_q.master && !s_ss_n;
    s_edge = sel && (s_sck != s_sck_d);

    busy_any = cfg_q.master ? m_busy : core_active;
    m_start  = dat_wr && cfg_q.master && !m_busy && !modf;
    m_edge   = m_busy && m_tick;

    core_restart = m_start || modf || (!cfg_q.master && !sel);
    core_load    = dat_wr && !busy_any;
    core_edge    = cfg_q.master ? m_edge : s_edge;
    core_in      = cfg_q.master ? miso_in : s_mosi;

    // configuration next state: mode fault overrides a write
    cfg_d = cfg_q;
    if (cfg_wr) begin
      cfg_d.cpol   = cfg_cpol;
      cfg_d.cpha   = cfg_cpha;
      cfg_d.master = cfg_master;
      cfg_d.dbl    = cfg_dbl;
      cfg_d.rate   = cfg_rate;
      cfg_d.ss_en  = cfg_ss_en;
    end
    if (modf) cfg_d.master = 1'b0;

    // master sequencing
    if (m_start)                         m_busy_d = 1'b1;
    else if (modf || (m_busy && core_last)) m_busy_d = 1'b0;
    else                                 m_busy_d = m_busy;

    if (m_start)     sck_ph_d = 1'b0;
    else if (m_edge) sck_ph_d = ~sck_ph;
    else             sck_ph_d = sck_ph;

    // flags
    done_set = core_last || modf;
    wcol_set = dat_wr && busy_any;
    flag_clr = dat_rd && seen_q;

    if (done_set)      done_d = 1'b1;
    else if (flag_clr) done_d = 1'b0;
    else               done_d = done_q;

    if (wcol_set)      wcol_d = 1'b1;
    else if (flag_clr) wcol_d = 1'b0;
    else               wcol_d = wcol_q;

    if (flag_clr)               seen_d = 1'b0;
    else if (stat_rd && done_q) seen_d = 1'b1;
    else                        seen_d = seen_q;

    rx_buf_d = core_rx_stb ? core_rx : rx_buf_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cfg_q    <= '0;
      m_busy   <= 1'b0;
      sck_ph   <= 1'b0;
      s_sck_d  <= 1'b0;
      done_q   <= 1'b0;
      wcol_q   <= 1'b0;
      seen_q   <= 1'b0;
      rx_buf_q <= '0;
    end else begin
      cfg_q    <= cfg_d;
      m_busy   <= m_busy_d;
      sck_ph   <= sck_ph_d;
      s_sck_d  <= s_sck;
      done_q   <= done_d;
      wcol_q   <= wcol_d;
      seen_q   <= seen_d;
      rx_buf_q <= rx_buf_d;
    end
  end

  assign sck_out   = cfg_q.cpol ^ (m_busy & sck_ph);
  assign sck_drive = cfg_q.master;
  assign mosi_out  = core_out;
  assign miso_out  = core_out;
  assign dat_rdata = rx_buf_q;
  assign done_o    = done_q;
  assign wcol_o    = wcol_q;
  assign master_o  = cfg_q.master;

endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk #(
  parameter int DW = 8
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_wr,
  input logic dat_wr,
  input logic dat_rd,
  input logic m_busy,
  input logic m_tick,
  input logic modf,
  input logic core_last,
  input logic busy_any,
  input logic seen_q,
  input logic done_set,
  input logic done_o,
  input logic wcol_o,
  input logic master_o,
  input logic sck_out
);

  localparam int EW = $clog2(2*DW) + 1;

  logic [EW-1:0] edge_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               edge_n <= '0;
    else if (!m_busy)         edge_n <= '0;
    else if (m_tick)          edge_n <= edge_n + EW'(1);
  end

  // R1: the clock only moves on a divider tick while running
  a_r1_sck_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_busy && !m_tick && !modf && !cfg_wr) |=> $stable(sck_out));

  // R4: the final edge of a transfer is the sixteenth
  a_r4_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
    (m_busy && m_tick && core_last) |-> (edge_n == EW'(2*DW-1)));

  // R7: a mode fault drops master mode and raises completion
  a_r7_mode_fault: assert property (@(posedge clk) disable iff (!rst_n)
    modf |=> (!master_o && done_o && !m_busy));

  // R9: a write during a transfer raises the collision flag
  a_r9_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && busy_any) |=> wcol_o);

  // R10: a new completion wins over a clearing read
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> done_o);

  // R10: an armed data read clears the flag
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && seen_q && !done_set) |=> !done_o);

endmodule

bind spi_xcvr spi_xcvr_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr    (cfg_wr),
  .dat_wr    (dat_wr),
  .dat_rd    (dat_rd),
  .m_busy    (m_busy),
  .m_tick    (m_tick),
  .modf      (modf),
  .core_last (core_last),
  .busy_any  (busy_any),
  .seen_q    (seen_q),
  .done_set  (done_set),
  .done_o    (done_o),
  .wcol_o    (wcol_o),
  .master_o  (master_o),
  .sck_out   (sck_out)
);

// File: tb/spi_xcvr_tb.sv
module spi_xcvr_tb;

  logic       clk, rst_n;
  logic       cfg_wr, cfg_cpol, cfg_cpha, cfg_master, cfg_dbl, cfg_ss_en;
  logic [1:0] cfg_rate;
  logic       dat_wr, dat_rd, stat_rd;
  logic [7:0] dat_wdata, dat_rdata;
  logic       done_o, wcol_o, master_o;
  logic       sck_in, sck_out, sck_drive, ss_n, mosi_in, mosi_out, miso_in, miso_out;
  logic       lb, miso_fix;

  int n_chk = 0;
  int n_err = 0;

  localparam int HP = 8;

  assign miso_in = lb ? mosi_out : miso_fix;

  spi_xcvr u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_master(cfg_master),
    .cfg_dbl(cfg_dbl), .cfg_rate(cfg_rate), .cfg_ss_en(cfg_ss_en),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd), .dat_rdata(dat_rdata),
    .stat_rd(stat_rd), .done_o(done_o), .wcol_o(wcol_o), .master_o(master_o),
    .sck_in(sck_in), .sck_out(sck_out), .sck_drive(sck_drive), .ss_n(ss_n),
    .mosi_in(mosi_in), .mosi_out(mosi_out), .miso_in(miso_in), .miso_out(miso_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic cpol, cpha, mst, dbl, input logic [1:0] rate,
                     input logic ss_en);
    @(negedge clk);
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_master = mst; cfg_dbl = dbl;
    cfg_rate = rate; cfg_ss_en = ss_en; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    @(negedge clk);
    dat_wdata = d; dat_wr = 1'b1;
    @(negedge clk);
    dat_wr = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); dat_rd = 1'b1;
    @(negedge clk); dat_rd = 1'b0;
  endtask

  task automatic pulse_stat();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic clear_flags();
    pulse_stat();
    pulse_rd();
  endtask

  task automatic wait_done();
    for (int k = 0; k < 3000 && !done_o; k++) @(negedge clk);
  endtask

  // Master transfer with monitoring of clock edges and MOSI at sample edges.
  task automatic master_xfer(input logic [7:0] tx, input logic cpol, cpha,
                             output logic [7:0] cap, output int edges);
    logic p;
    cap = '0; edges = 0;
    pulse_wr(tx);
    p = sck_out;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (sck_out != p) begin
        edges++;
        if ((p == cpol) != cpha) cap = {cap[6:0], mosi_out};
        p = sck_out;
      end
      if (done_o) break;
    end
  endtask

  task automatic t_reset();
    chk(done_o == 0,    "R11 done",   32'(done_o), 0);
    chk(wcol_o == 0,    "R11 wcol",   32'(wcol_o), 0);
    chk(master_o == 0,  "R11 master", 32'(master_o), 0);
    chk(sck_out == 0,   "R11 sck",    32'(sck_out), 0);
    chk(dat_rdata == 0, "R11 rdata",  32'(dat_rdata), 0);
  endtask

  task automatic t_mode(input logic cpol, cpha, input logic [7:0] tx);
    logic [7:0] cap; int edges;
    string tag;
    tag = cpha ? "R3" : "R2";
    lb = 1'b1;
    cfg(cpol, cpha, 1'b1, 1'b0, 2'b00, 1'b1);
    clear_flags();
    chk(sck_out == cpol, "R1 idle level", 32'(sck_out), 32'(cpol));
    master_xfer(tx, cpol, cpha, cap, edges);
    chk(done_o == 1, {tag, " done"}, 32'(done_o), 1);
    chk(edges == 16, "R4 edge count", 32'(edges), 16);
    chk(cap == tx, "R4 mosi msb first", 32'(cap), 32'(tx));
    chk(dat_rdata == tx, {tag, " loopback rx"}, 32'(dat_rdata), 32'(tx));
    chk(sck_out == cpol, "R1 level after", 32'(sck_out), 32'(cpol));
  endtask

  task automatic t_fixed_miso(input logic v);
    logic [7:0] cap; int edges;
    lb = 1'b0; miso_fix = v;
    cfg(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1);
    clear_flags();
    master_xfer(8'h5A, 1'b0, 1'b0, cap, edges);
    chk(dat_rdata == {8{v}}, "R4 rx constant", 32'(dat_rdata), 32'({8{v}}));
    lb = 1'b1;
  endtask

  task automatic t_rate(input logic dbl, input logic [1:0] rate, input int exp_p,
                        input string req);
    int t, t1, t2;
    logic p;
    t = 0; t1 = -1; t2 = -1;
    cfg(1'b0, 1'b0, 1'b1, dbl, rate, 1'b1);
    clear_flags();
    pulse_wr(8'h96);
    p = sck_out;
    for (int k = 0; k < 2000 && t2 < 0; k++) begin
      @(negedge clk);
      t++;
      if (sck_out && !p) begin
        if (t1 < 0) t1 = t;
        else        t2 = t;
      end
      p = sck_out;
    end
    chk((t2 - t1) == exp_p, req, 32'(t2 - t1), 32'(exp_p));
    wait_done();
  endtask

  task automatic t_wcol();
    lb = 1'b1;
    cfg(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1);
    clear_flags();
    pulse_wr(8'hA5);
    repeat (5) @(negedge clk);
    pulse_wr(8'h0F);
    chk(wcol_o == 1, "R9 collision flag", 32'(wcol_o), 1);
    wait_done();
    chk(dat_rdata == 8'hA5, "R9 write ignored", 32'(dat_rdata), 32'hA5);
    clear_flags();
    chk(wcol_o == 0, "R10 wcol cleared", 32'(wcol_o), 0);
    chk(done_o == 0, "R10 done cleared", 32'(done_o), 0);
  endtask

  task automatic t_flag();
    lb = 1'b1;
    cfg(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1);
    clear_flags();
    pulse_wr(8'h11);
    wait_done();
    pulse_rd();
    chk(done_o == 1, "R10 read alone keeps flag", 32'(done_o), 1);
    pulse_stat();
    pulse_wr(8'h22);
    // completion lands on the 32nd edge after the write edge
    repeat (31) @(negedge clk);
    dat_rd = 1'b1;
    @(negedge clk);
    dat_rd = 1'b0;
    chk(done_o == 1, "R10 set wins over clear", 32'(done_o), 1);
    chk(dat_rdata == 8'h22, "R10 rx at race", 32'(dat_rdata), 32'h22);
    pulse_rd();
    chk(done_o == 1, "R10 status read consumed", 32'(done_o), 1);
    clear_flags();
    chk(done_o == 0, "R10 cleared", 32'(done_o), 0);
  endtask

  task automatic t_modf();
    cfg(1'b1, 1'b0, 1'b1, 1'b0, 2'b01, 1'b1);
    clear_flags();
    pulse_wr(8'hC3);
    repeat (20) @(negedge clk);
    ss_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(master_o == 0, "R7 master cleared", 32'(master_o), 0);
    chk(done_o == 1, "R7 done set", 32'(done_o), 1);
    chk(sck_out == 1, "R7 clock idle", 32'(sck_out), 1);
    chk(sck_drive == 0, "R7 clock released", 32'(sck_drive), 0);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(master_o == 0, "R7 stays slave", 32'(master_o), 0);
    cfg(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0);
    chk(master_o == 1, "R7 master again", 32'(master_o), 1);
    ss_n = 1'b0;
    repeat (8) @(negedge clk);
    chk(master_o == 1, "R7 ss ignored when disabled", 32'(master_o), 1);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_slave(input logic cpol, cpha, input logic [1:0] rate, input logic dbl,
                         input logic [7:0] mtx, input logic [7:0] stx);
    logic [7:0] cap;
    cap = '0;
    sck_in = cpol;
    cfg(cpol, cpha, 1'b0, dbl, rate, 1'b1);
    clear_flags();
    pulse_wr(stx);
    @(negedge clk); ss_n = 1'b0;
    repeat (4) @(negedge clk);
    if (!cpha) chk(miso_out == stx[7], "R12 first bit on select", 32'(miso_out), 32'(stx[7]));
    for (int i = 7; i >= 0; i--) begin
      if (!cpha) begin
        mosi_in = mtx[i];
        repeat (HP) @(negedge clk);
        cap = {cap[6:0], miso_out};
        sck_in = ~cpol;
        repeat (HP) @(negedge clk);
        sck_in = cpol;
      end else begin
        repeat (HP) @(negedge clk);
        sck_in = ~cpol;
        mosi_in = mtx[i];
        repeat (HP) @(negedge clk);
        cap = {cap[6:0], miso_out};
        sck_in = cpol;
      end
    end
    repeat (HP) @(negedge clk);
    chk(done_o == 1, "R8 slave done", 32'(done_o), 1);
    chk(dat_rdata == mtx, "R8 slave rx", 32'(dat_rdata), 32'(mtx));
    chk(cap == stx, "R8 slave miso", 32'(cap), 32'(stx));
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_wr = 0; cfg_cpol = 0; cfg_cpha = 0; cfg_master = 0; cfg_dbl = 0;
    cfg_rate = 0; cfg_ss_en = 0;
    dat_wr = 0; dat_rd = 0; stat_rd = 0; dat_wdata = 0;
    sck_in = 0; ss_n = 1; mosi_in = 0; lb = 1; miso_fix = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();

    t_mode(1'b0, 1'b0, 8'hB4);
    t_mode(1'b1, 1'b0, 8'h3C);
    t_mode(1'b0, 1'b1, 8'hE1);
    t_mode(1'b1, 1'b1, 8'h5A);
    t_fixed_miso(1'b1);
    t_fixed_miso(1'b0);

    t_rate(1'b0, 2'b00, 4,   "R5 div 4");
    t_rate(1'b0, 2'b01, 16,  "R5 div 16");
    t_rate(1'b0, 2'b10, 64,  "R5 div 64");
    t_rate(1'b0, 2'b11, 128, "R5 div 128");
    t_rate(1'b1, 2'b00, 2,   "R6 div 2");
    t_rate(1'b1, 2'b01, 8,   "R6 div 8");
    t_rate(1'b1, 2'b10, 32,  "R6 div 32");
    t_rate(1'b1, 2'b11, 64,  "R6 div 64");

    t_wcol();
    t_flag();
    t_modf();

    t_slave(1'b0, 1'b0, 2'b00, 1'b0, 8'hC5, 8'h6B);
    t_slave(1'b0, 1'b0, 2'b11, 1'b1, 8'hC5, 8'h6B);
    t_slave(1'b1, 1'b1, 2'b10, 1'b0, 8'h2D, 8'hF0);
    t_slave(1'b0, 1'b1, 2'b01, 1'b1, 8'h81, 8'h7E);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule